// File: doc/BRIEF.md
# Six-Instruction Processor Control Unit

This block is the sequencing half of a small programmable processor with a 16-bit instruction word. It owns the program counter and the instruction register. A state machine fetches each instruction word from an external instruction memory, decodes the 4-bit opcode in the top nibble, and then spends one execute state driving the register-file, ALU and data-memory control lines for that instruction. The register file, the ALU, both memories and the write-back multiplexer are outside the block. The block only sends them addresses, selects and strobes. The one value it reads back from the datapath is a flag that says whether register-file read port P is all zeros.

Six opcodes are defined: load from data memory, store to data memory, add, load an 8-bit constant, subtract, and jump-if-zero. The jump is PC-relative. Its 8-bit offset is a two's-complement value, and it is applied to a PC that was already incremented during fetch. The jump adder therefore adds the sign-extended offset and subtracts one in the same operation, so an offset of +1 lands on the instruction after the jump. A jump that is taken costs one extra state.

States: `ST_INIT` (clears the PC) goes to `ST_FETCH`. `ST_FETCH` goes to `ST_DECODE`. `ST_DECODE` goes to one of `ST_LOAD`, `ST_STORE`, `ST_ADD`, `ST_LDC`, `ST_SUB` or `ST_JZ`, chosen by opcode, or goes back to `ST_FETCH` for an undefined opcode. `ST_JZ` goes to `ST_JUMP` when the zero flag is set and to `ST_FETCH` when it is clear. Every other execute state and `ST_JUMP` return to `ST_FETCH`. Reset from any state leads to `ST_INIT`.

Top module: `isa6_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `ST_INIT`. `ST_INIT` drives every strobe low and holds the PC at zero, so the first fetch after reset reads address 0.
- R2: In `ST_FETCH`, `imem_rd` is 1, `imem_addr` shows the PC, the word on `imem_data` is captured into the instruction register, and the PC advances by one. `imem_addr` shows the PC in every state.
- R3: `ST_DECODE` asserts no strobe. It selects the execute state from the opcode in bits 15:12: 0000 load, 0001 store, 0010 add, 0011 load-constant, 0100 subtract, 0101 jump-if-zero.
- R4: Load drives `dmem_addr` with bits 7:0, asserts `dmem_rd` and `rf_wen`, sets `rf_wsel`=01 (memory), and sets `rf_waddr` to bits 11:8.
- R5: Store drives `dmem_addr` with bits 7:0, asserts `dmem_wr`, and reads the register named in bits 11:8 on port P (`rf_paddr`, `rf_pen`).
- R6: Add and subtract read bits 7:4 on port P and bits 3:0 on port Q. They write the register in bits 11:8 with `rf_wsel`=00 (ALU), and set `alu_op` to 01 for add or 10 for subtract.
- R7: Load-constant sets `rf_wsel`=10 (constant), drives `rf_wconst` with bits 7:0, and writes the register in bits 11:8.
- R8: Jump-if-zero reads the register in bits 11:8 on port P. It enters `ST_JUMP` only when `rp_zero` is 1 at the end of that state; otherwise it returns to fetch.
- R9: `ST_JUMP` asserts no strobe and loads the PC with PC + sign-extended bits 7:0 − 1.
- R10: Opcodes 0110 through 1111 run as a no-op. Decode returns straight to fetch with no strobe asserted and the PC left unchanged.
- R11: From one fetch to the next takes 3 cycles for a defined instruction, 4 for a taken jump and 2 for an undefined opcode.
- R12: Any output not named for the current state is 0. This covers `alu_op`=00 outside add and subtract. `dmem_rd` and `dmem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 16 | Instruction address, the PC |
| imem_rd | output | 1 | Instruction read strobe |
| imem_data | input | 16 | Instruction word, valid in the same cycle |
| dmem_addr | output | 8 | Data-memory address |
| dmem_rd | output | 1 | Data-memory read strobe |
| dmem_wr | output | 1 | Data-memory write strobe |
| rf_wsel | output | 2 | Write-back source: 00 ALU, 01 memory, 10 constant |
| rf_wconst | output | 8 | Constant for write-back |
| rf_waddr | output | 4 | Register write address |
| rf_wen | output | 1 | Register write enable |
| rf_paddr | output | 4 | Read port P address |
| rf_pen | output | 1 | Read port P enable |
| rf_qaddr | output | 4 | Read port Q address |
| rf_qen | output | 1 | Read port Q enable |
| alu_op | output | 2 | 00 pass, 01 add, 10 subtract |
| rp_zero | input | 1 | Port P data is all zeros |

## Verification
The run opens with a directed program that goes through every defined opcode, one undefined opcode, and two taken jumps with offsets +1 and −128, with the zero flag held high. Together these show the field routing for each opcode, the no-op path, and the minus-one adjustment on both a forward and a wrapping backward jump. The rest of memory holds random words, including undefined opcodes, and the zero flag is random every cycle. This separates taken from untaken jumps and checks the decoding of arbitrary register and immediate fields. A reset part way through the run shows that the block restarts cleanly from any state.

// File: rtl/isa6_pkg.sv
`timescale 1ns/1ps
package isa6_pkg;
    localparam int INSN_W = 16;
    localparam int OP_W   = 4;
    localparam int REG_W  = 4;
    localparam int IMM_W  = 8;
    localparam int OP_LSB = INSN_W - OP_W;
    localparam int RA_LSB = OP_LSB - REG_W;
    localparam int RB_LSB = RA_LSB - REG_W;

    localparam logic [OP_W-1:0] OPC_LOAD  = 4'b0000;
    localparam logic [OP_W-1:0] OPC_STORE = 4'b0001;
    localparam logic [OP_W-1:0] OPC_ADD   = 4'b0010;
    localparam logic [OP_W-1:0] OPC_LDC   = 4'b0011;
    localparam logic [OP_W-1:0] OPC_SUB   = 4'b0100;
    localparam logic [OP_W-1:0] OPC_JZ    = 4'b0101;

    localparam logic [1:0] WSEL_ALU   = 2'b00;
    localparam logic [1:0] WSEL_MEM   = 2'b01;
    localparam logic [1:0] WSEL_CONST = 2'b10;

    localparam logic [1:0] ALU_PASS = 2'b00;
    localparam logic [1:0] ALU_ADD  = 2'b01;
    localparam logic [1:0] ALU_SUB  = 2'b10;

    typedef enum logic [3:0] {
        ST_INIT, ST_FETCH, ST_DECODE,
        ST_LOAD, ST_STORE, ST_ADD, ST_LDC, ST_SUB, ST_JZ,
        ST_JUMP
    } state_t;
endpackage

// File: rtl/isa6_pc.sv
`timescale 1ns/1ps
module isa6_pc #(
    parameter int PC_W  = 16,
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic             jmp,
    input  logic [OFF_W-1:0] off,
    output logic [PC_W-1:0]  pc
);
    localparam logic [PC_W-1:0] ONE    = {{(PC_W-1){1'b0}}, 1'b1};
    localparam logic [PC_W-1:0] MINUS1 = {PC_W{1'b1}};

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] target;

    generate
        if (PC_W > OFF_W) begin : g_sext
            assign off_ext = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
        end else begin : g_trunc
            assign off_ext = off[PC_W-1:0];
        end
    endgenerate

    // fetch already advanced the PC, so the relative target folds in -1
    assign target = pc + off_ext + MINUS1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pc <= '0;
        end else if (jmp) begin
            pc <= target;
        end else if (inc) begin
            pc <= pc + ONE;
        end
    end
endmodule

// File: rtl/isa6_ir.sv
`timescale 1ns/1ps
module isa6_ir
    import isa6_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [INSN_W-1:0] din,
    output logic [OP_W-1:0]   op,
    output logic [REG_W-1:0]  ra,
    output logic [REG_W-1:0]  rb,
    output logic [REG_W-1:0]  rc,
    output logic [IMM_W-1:0]  imm
);
    logic [INSN_W-1:0] word;

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (ld) begin
            word <= din;
        end
    end

    assign op  = word[OP_LSB +: OP_W];
    assign ra  = word[RA_LSB +: REG_W];
    assign rb  = word[RB_LSB +: REG_W];
    assign rc  = word[REG_W-1:0];
    assign imm = word[IMM_W-1:0];
endmodule

// File: rtl/isa6_fsm.sv
`timescale 1ns/1ps
module isa6_fsm
    import isa6_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  op,
    input  logic [REG_W-1:0] ra,
    input  logic [REG_W-1:0] rb,
    input  logic [REG_W-1:0] rc,
    input  logic [IMM_W-1:0] imm,
    input  logic             rp_zero,
    output state_t           state,
    output logic             pc_clr,
    output logic             pc_inc,
    output logic             pc_jmp,
    output logic             ir_ld,
    output logic             imem_rd,
    output logic [IMM_W-1:0] dmem_addr,
    output logic             dmem_rd,
    output logic             dmem_wr,
    output logic [1:0]       rf_wsel,
    output logic [IMM_W-1:0] rf_wconst,
    output logic [REG_W-1:0] rf_waddr,
    output logic             rf_wen,
    output logic [REG_W-1:0] rf_paddr,
    output logic             rf_pen,
    output logic [REG_W-1:0] rf_qaddr,
    output logic             rf_qen,
    output logic [1:0]       alu_op
);
    state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_INIT;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = ST_FETCH;
        unique case (state)
            ST_INIT:   nxt = ST_FETCH;
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                case (op)
                    OPC_LOAD:  nxt = ST_LOAD;
                    OPC_STORE: nxt = ST_STORE;
                    OPC_ADD:   nxt = ST_ADD;
                    OPC_LDC:   nxt = ST_LDC;
                    OPC_SUB:   nxt = ST_SUB;
                    OPC_JZ:    nxt = ST_JZ;
                    default:   nxt = ST_FETCH;
                endcase
            end
            ST_JZ:     nxt = rp_zero ? ST_JUMP : ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

    always_comb begin
        pc_clr    = 1'b0;
        pc_inc    = 1'b0;
        pc_jmp    = 1'b0;
        ir_ld     = 1'b0;
        imem_rd   = 1'b0;
        dmem_addr = '0;
        dmem_rd   = 1'b0;
        dmem_wr   = 1'b0;
        rf_wsel   = WSEL_ALU;
        rf_wconst = '0;
        rf_waddr  = '0;
        rf_wen    = 1'b0;
        rf_paddr  = '0;
        rf_pen    = 1'b0;
        rf_qaddr  = '0;
        rf_qen    = 1'b0;
        alu_op    = ALU_PASS;
        unique case (state)
            ST_INIT: pc_clr = 1'b1;
            ST_FETCH: begin
                imem_rd = 1'b1;
                ir_ld   = 1'b1;
                pc_inc  = 1'b1;
            end
            ST_LOAD: begin
                dmem_addr = imm;
                dmem_rd   = 1'b1;
                rf_wsel   = WSEL_MEM;
                rf_waddr  = ra;
                rf_wen    = 1'b1;
            end
            ST_STORE: begin
                dmem_addr = imm;
                dmem_wr   = 1'b1;
                rf_paddr  = ra;
                rf_pen    = 1'b1;
            end
            ST_ADD, ST_SUB: begin
                rf_paddr = rb;
                rf_pen   = 1'b1;
                rf_qaddr = rc;
                rf_qen   = 1'b1;
                rf_wsel  = WSEL_ALU;
                rf_waddr = ra;
                rf_wen   = 1'b1;
                alu_op   = (state == ST_SUB) ? ALU_SUB : ALU_ADD;
            end
            ST_LDC: begin
                rf_wsel   = WSEL_CONST;
                rf_wconst = imm;
                rf_waddr  = ra;
                rf_wen    = 1'b1;
            end
            ST_JZ: begin
                rf_paddr = ra;
                rf_pen   = 1'b1;
            end
            ST_JUMP: pc_jmp = 1'b1;
            default: ;
        endcase
    end

    AST_WRITE_ONLY_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
        rf_wen |-> (state == ST_LOAD || state == ST_ADD || state == ST_SUB || state == ST_LDC)); // R12
    AST_DECODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE) |-> !(imem_rd || dmem_rd || dmem_wr || rf_wen || rf_pen || rf_qen)); // R3
endmodule

// File: rtl/isa6_ctrl.sv
`timescale 1ns/1ps
module isa6_ctrl
    import isa6_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [PC_W-1:0]   imem_addr,
    output logic              imem_rd,
    input  logic [INSN_W-1:0] imem_data,
    output logic [IMM_W-1:0]  dmem_addr,
    output logic              dmem_rd,
    output logic              dmem_wr,
    output logic [1:0]        rf_wsel,
    output logic [IMM_W-1:0]  rf_wconst,
    output logic [REG_W-1:0]  rf_waddr,
    output logic              rf_wen,
    output logic [REG_W-1:0]  rf_paddr,
    output logic              rf_pen,
    output logic [REG_W-1:0]  rf_qaddr,
    output logic              rf_qen,
    output logic [1:0]        alu_op,
    input  logic              rp_zero
);
    localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

    state_t           st;
    logic             pc_clr, pc_inc, pc_jmp, ir_ld;
    logic [OP_W-1:0]  op;
    logic [REG_W-1:0] ra, rb, rc;
    logic [IMM_W-1:0] imm;
    logic [PC_W-1:0]  pc;

    isa6_pc #(.PC_W(PC_W), .OFF_W(IMM_W)) u_pc (
        .clk(clk), .rst(rst), .clr(pc_clr), .inc(pc_inc), .jmp(pc_jmp),
        .off(imm), .pc(pc)
    );

    isa6_ir u_ir (
        .clk(clk), .rst(rst), .ld(ir_ld), .din(imem_data),
        .op(op), .ra(ra), .rb(rb), .rc(rc), .imm(imm)
    );

    isa6_fsm u_fsm (
        .clk(clk), .rst(rst), .op(op), .ra(ra), .rb(rb), .rc(rc), .imm(imm),
        .rp_zero(rp_zero), .state(st),
        .pc_clr(pc_clr), .pc_inc(pc_inc), .pc_jmp(pc_jmp), .ir_ld(ir_ld),
        .imem_rd(imem_rd), .dmem_addr(dmem_addr), .dmem_rd(dmem_rd),
        .dmem_wr(dmem_wr), .rf_wsel(rf_wsel), .rf_wconst(rf_wconst),
        .rf_waddr(rf_waddr), .rf_wen(rf_wen), .rf_paddr(rf_paddr),
        .rf_pen(rf_pen), .rf_qaddr(rf_qaddr), .rf_qen(rf_qen), .alu_op(alu_op)
    );

    assign imem_addr = pc;

    AST_INIT_CLEARS_PC: assert property (@(posedge clk) disable iff (rst)
        (st == ST_INIT) |=> (imem_addr == '0)); // R1
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FETCH) |=> (imem_addr == $past(imem_addr) + PC_ONE)); // R2
    AST_JUMP_NEEDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (st == ST_JUMP) |-> $past(rp_zero)); // R8
    AST_EXEC_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DECODE || st == ST_JZ) |=> $stable(imem_addr)); // R10
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(dmem_rd && dmem_wr)); // R12
    AST_ONE_ALU_OP: assert property (@(posedge clk) disable iff (rst)
        $countones(alu_op) <= 1); // R6
endmodule

// File: tb/isa6_ctrl_bench.sv
`timescale 1ns/1ps
module isa6_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rp_zero = 1'b0;
    logic [15:0] imem_addr;
    logic        imem_rd;
    logic [15:0] imem_data;
    logic [7:0]  dmem_addr;
    logic        dmem_rd, dmem_wr;
    logic [1:0]  rf_wsel;
    logic [7:0]  rf_wconst;
    logic [3:0]  rf_waddr;
    logic        rf_wen;
    logic [3:0]  rf_paddr;
    logic        rf_pen;
    logic [3:0]  rf_qaddr;
    logic        rf_qen;
    logic [1:0]  alu_op;

    logic [15:0] prog [0:255];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign imem_data = prog[imem_addr[7:0]];

    isa6_ctrl u_isa6_ctrl (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rd(imem_rd),
        .imem_data(imem_data), .dmem_addr(dmem_addr), .dmem_rd(dmem_rd),
        .dmem_wr(dmem_wr), .rf_wsel(rf_wsel), .rf_wconst(rf_wconst),
        .rf_waddr(rf_waddr), .rf_wen(rf_wen), .rf_paddr(rf_paddr),
        .rf_pen(rf_pen), .rf_qaddr(rf_qaddr), .rf_qen(rf_qen),
        .alu_op(alu_op), .rp_zero(rp_zero)
    );

    // model states: 0 init,1 fetch,2 decode,3 load,4 store,5 add,6 ldc,7 sub,8 jz,9 jump
    function automatic logic [53:0] expect_vec(int st, logic [15:0] pc, logic [15:0] ir);
        logic ird, rd, wr, we, pe, qe;
        logic [7:0] da, wc;
        logic [1:0] ws, ao;
        logic [3:0] wa, pa, qa;
        ird = 0; rd = 0; wr = 0; we = 0; pe = 0; qe = 0;
        da = 0; wc = 0; ws = 0; ao = 0; wa = 0; pa = 0; qa = 0;
        case (st)
            1: ird = 1;
            3: begin da = ir[7:0]; rd = 1; ws = 2'b01; wa = ir[11:8]; we = 1; end
            4: begin da = ir[7:0]; wr = 1; pa = ir[11:8]; pe = 1; end
            5, 7: begin
                pa = ir[7:4]; pe = 1; qa = ir[3:0]; qe = 1;
                wa = ir[11:8]; we = 1; ao = (st == 5) ? 2'b01 : 2'b10;
            end
            6: begin ws = 2'b10; wc = ir[7:0]; wa = ir[11:8]; we = 1; end
            8: begin pa = ir[11:8]; pe = 1; end
            default: ;
        endcase
        return {pc, ird, da, rd, wr, ws, wc, wa, we, pa, pe, qa, qe, ao};
    endfunction

    function automatic string tag_of(int st, int prev, logic [15:0] ir);
        case (st)
            0: return "R1";
            1: return (prev == 9) ? "R9" : (prev == 0) ? "R1" : "R2";
            2: return (ir[15:12] > 4'd5) ? "R10" : "R3";
            3: return "R4";
            4: return "R5";
            5, 7: return "R6";
            6: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        int m_st, m_prev, last_fetch, exp_gap;
        bit have_fetch;
        logic [15:0] m_pc, m_ir;
        logic [53:0] obs;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 256; i++) prog[i] = 16'($urandom);
        prog[0] = 16'h0A09;   // load r10 <- d[9]
        prog[1] = 16'h1B0C;   // store d[12] <- r11
        prog[2] = 16'h2123;   // add r1 = r2 + r3
        prog[3] = 16'h4456;   // sub r4 = r5 - r6
        prog[4] = 16'hF000;   // undefined
        prog[5] = 16'h3C7E;   // r12 <- 0x7e
        prog[6] = 16'h5201;   // jz +1 -> next word
        prog[7] = 16'h5380;   // jz -128 -> wraps backward
        m_st = 0; m_prev = 0; m_pc = 0; m_ir = 0;
        have_fetch = 0; last_fetch = 0; exp_gap = 0;
        repeat (2) @(posedge clk);
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            rst = (cyc == 1500 || cyc == 1501);
            rp_zero = (cyc < 40) ? 1'b1 : 1'($urandom);
            #1;
            obs = {imem_addr, imem_rd, dmem_addr, dmem_rd, dmem_wr, rf_wsel,
                   rf_wconst, rf_waddr, rf_wen, rf_paddr, rf_pen, rf_qaddr,
                   rf_qen, alu_op};
            check(tag_of(m_st, m_prev, m_ir), 64'(obs), 64'(expect_vec(m_st, m_pc, m_ir)));
            check("R12", 64'(dmem_rd & dmem_wr), 64'd0);
            if (m_st == 1) begin
                if (have_fetch) check("R11", 64'(cyc - last_fetch), 64'(exp_gap));
                have_fetch = 1;
                last_fetch = cyc;
            end
            m_prev = m_st;
            if (rst) begin
                m_st = 0; m_pc = 0; m_ir = 0; have_fetch = 0;
            end else begin
                case (m_st)
                    0: begin m_pc = 0; m_st = 1; end
                    1: begin m_ir = prog[m_pc[7:0]]; m_pc = m_pc + 16'd1; m_st = 2; end
                    2: begin
                        case (m_ir[15:12])
                            4'd0: m_st = 3;
                            4'd1: m_st = 4;
                            4'd2: m_st = 5;
                            4'd3: m_st = 6;
                            4'd4: m_st = 7;
                            4'd5: m_st = 8;
                            default: m_st = 1;
                        endcase
                        exp_gap = (m_ir[15:12] > 4'd5) ? 2 : 3;
                    end
                    8: begin
                        m_st = rp_zero ? 9 : 1;
                        exp_gap = rp_zero ? 4 : 3;
                    end
                    9: begin
                        m_pc = m_pc + {{8{m_ir[7]}}, m_ir[7:0]} - 16'd1;
                        m_st = 1;
                    end
                    default: m_st = 1;
                endcase
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule